// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave end of a serial link through which an external controller reads and writes a small bank of configuration registers. The registers have different widths. Every access starts with an instruction byte. That byte gives the direction of the access and a register address. A data phase follows, and it moves exactly as many bits as the addressed register holds. Several instruction/data pairs may follow one another while chip select stays low.

Chip select, the serial clock, the active-high port reset and the incoming data bit are all brought into the system clock domain. Edges are detected there, so the system clock must run at least four times faster than the serial clock. Two bits of the control register choose the bit order and which pin carries read data. The port picks up a new setting only at the start of the next instruction. A port reset or a chip-select release abandons an unfinished access without disturbing any register.

Top module: `sreg_port`

## Requirements
- R1: After reset every register reads as zero, both output enables are low, and the port uses MSB-first order with 2-wire pin use.
- R2: In the instruction byte, bit 7 set means read and clear means write. Bits 5:0 are the register address. Bit 6 has no effect.
- R3: Address 0 is the 32-bit control register. Address 1 holds 8 bits, address 2 holds 16 bits and address 3 holds 32 bits. The data phase is exactly that many bits long.
- R4: A write changes the register only after every bit of the register has been shifted in.
- R5: Instruction and write bits are taken on rising serial-clock edges. Read bits change on falling edges. The first read bit appears after the falling edge that follows the eighth instruction bit.
- R6: When control bit 0 is 1, both phases send bit 0 first. When it is 0, both phases send the top bit first (bit 7 of the instruction, the register's highest bit for data).
- R7: When control bit 1 is 0, read data leaves on the bidirectional pin with sdio_oe high and sdo_oe low. When it is 1, read data leaves on sdo_o with sdo_oe high and sdio_oe low.
- R8: While chip select is high, both enables are low and serial-clock edges are ignored. Raising chip select during an access abandons it with no partial write. The next falling edge of chip select begins an instruction.
- R9: A pulse on io_reset abandons the current access. The next eight rising edges form an instruction, and register contents are kept.
- R10: An unmapped address has an 8-bit data phase. Reads of it return zeros and writes to it change nothing.
- R11: A change to the control bits takes effect from the next instruction, including one that follows in the same chip-select window.
- R12: After a data phase completes, the next rising edges are taken as a new instruction without a chip-select toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| io_reset | input | 1 | Active-high port resynchronisation |
| sdio_i | input | 1 | Bidirectional data pin, input side |
| sdio_o | output | 1 | Bidirectional data pin, output value |
| sdio_oe | output | 1 | Drive enable for the bidirectional pin |
| sdo_o | output | 1 | Dedicated read data output |
| sdo_oe | output | 1 | Drive enable for sdo_o |

## Verification
The bench sweeps every mapped register through every combination of bit order and pin use. A design that reversed bits or took a wrong data length would return scrambled or shifted readback. Accesses are cut short by a chip-select release and by a port reset. A design that committed partial data, or that lost instruction alignment afterwards, would corrupt the register or misread the next access. Unmapped addresses, the ignored instruction bit, clock toggling while deselected and a control change followed by an access in the same window are also exercised. A faulty design would show stray writes, a wrong register, false starts or a stale bit order.

// File: rtl/sp_pkg.sv
// Shared constants and register-map helpers for the serial register port.
// Assumes a six-bit address space with four mapped registers at 0..3.
package sp_pkg;
    localparam int ADDR_W  = 6;
    localparam int DW      = 32;          // widest register
    localparam int NREG    = 4;           // mapped registers at 0..NREG-1
    localparam int CNT_W   = $clog2(DW);  // bit counter width
    localparam int INSN_W  = 8;
    localparam int CTRL_LSB_BIT = 0;      // control: LSB-first order
    localparam int CTRL_W3_BIT  = 1;      // control: separate output pin

    // Index of the top bit of a register; unmapped addresses act as 8 bits.
    function automatic logic [CNT_W-1:0] reg_last_bit(input logic [ADDR_W-1:0] a);
        case (a)
            6'd0:    return CNT_W'(31);
            6'd1:    return CNT_W'(7);
            6'd2:    return CNT_W'(15);
            6'd3:    return CNT_W'(31);
            default: return CNT_W'(7);
        endcase
    endfunction

    // Mask of the bits a register really stores.
    function automatic logic [DW-1:0] reg_mask(input logic [ADDR_W-1:0] a);
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < DW; i++)
            if (CNT_W'(i) <= reg_last_bit(a)) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/sp_sync.sv
// Two-stage synchroniser with one extra history stage for edge detection.
// Assumes the inputs are slow compared to clk; RST_VAL sets the idle level.
module sp_sync #(
    parameter int              W       = 4,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta;

    // Carry the asynchronous inputs through two flops, then keep one more for history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta   <= RST_VAL;
            sync_o <= RST_VAL;
            prev_o <= RST_VAL;
        end else begin
            meta   <= async_i;
            sync_o <= meta;
            prev_o <= sync_o;
        end
    end
endmodule

// File: rtl/sp_regbank.sv
// Register storage: one control register plus data registers of several widths.
// Unmapped addresses read as zero and ignore writes; storage is trimmed to each width.
module sp_regbank
    import sp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              ctrl_lsb,
    output logic              ctrl_w3
);
    logic [DW-1:0] regs [NREG];

    // Commit a completed write to the matching mapped register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NREG; i++)
                if (wr_addr == ADDR_W'(i))
                    regs[i] <= wr_data & reg_mask(ADDR_W'(i));
        end
    end

    // Select the addressed register for readback, zero when unmapped.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
    end

    assign ctrl_lsb = regs[0][CTRL_LSB_BIT];
    assign ctrl_w3  = regs[0][CTRL_W3_BIT];
endmodule

// File: rtl/sp_engine.sv
// Serial protocol engine: instruction capture, data shifting, read driving, write commit.
// Assumes synchronised, edge-detected inputs and at least two clk cycles between serial edges.
module sp_engine
    import sp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              io_rst,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din,
    input  logic              ctrl_lsb,
    input  logic              ctrl_w3,
    input  logic [DW-1:0]     rd_data,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              wr_en,
    output logic [DW-1:0]     wr_data,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              sdo_o,
    output logic              sdo_oe,
    output logic              at_start,
    output logic              cfg_lsb,
    output logic              cfg_w3
);
    typedef enum logic { ST_INSN, ST_DATA } phase_t;

    phase_t             phase;
    logic [INSN_W-1:0]  insn;
    logic [INSN_W-1:0]  insn_next;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   last_idx;
    logic [CNT_W-1:0]   idx;
    logic               is_rd;
    logic               load_pend;
    logic [DW-1:0]      shadow;
    logic               out_bit;
    logic               oe_q;

    assign at_start  = (phase == ST_INSN) && (cnt == '0);
    assign insn_next = cfg_lsb ? {din, insn[INSN_W-1:1]} : {insn[INSN_W-2:0], din};
    assign idx       = cfg_lsb ? cnt : (last_idx - cnt);
    assign wr_data   = shadow;

    // Advance the protocol on serial edges; abandon on deselect or port reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= ST_INSN;
            insn      <= '0;
            cnt       <= '0;
            last_idx  <= '0;
            is_rd     <= 1'b0;
            acc_addr  <= '0;
            load_pend <= 1'b0;
            shadow    <= '0;
            out_bit   <= 1'b0;
            oe_q      <= 1'b0;
            wr_en     <= 1'b0;
            cfg_lsb   <= 1'b0;
            cfg_w3    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (at_start && !sclk_rise) begin
                cfg_lsb <= ctrl_lsb;
                cfg_w3  <= ctrl_w3;
            end
            if (!cs_act || io_rst) begin
                phase     <= ST_INSN;
                cnt       <= '0;
                load_pend <= 1'b0;
                oe_q      <= 1'b0;
            end else begin
                if (load_pend) begin
                    shadow    <= rd_data;
                    load_pend <= 1'b0;
                end
                if (sclk_rise) begin
                    if (phase == ST_INSN) begin
                        insn <= insn_next;
                        if (cnt == CNT_W'(INSN_W - 1)) begin
                            phase     <= ST_DATA;
                            cnt       <= '0;
                            is_rd     <= insn_next[7];
                            acc_addr  <= insn_next[ADDR_W-1:0];
                            last_idx  <= reg_last_bit(insn_next[ADDR_W-1:0]);
                            shadow    <= '0;
                            load_pend <= insn_next[7];
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end else begin
                        if (!is_rd) shadow[idx] <= din;
                        if (cnt == last_idx) begin
                            phase <= ST_INSN;
                            cnt   <= '0;
                            oe_q  <= 1'b0;
                            if (!is_rd) wr_en <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                if (sclk_fall && phase == ST_DATA && is_rd) begin
                    out_bit <= shadow[idx];
                    oe_q    <= 1'b1;
                end
            end
        end
    end

    assign sdio_o  = out_bit;
    assign sdo_o   = out_bit;
    assign sdio_oe = oe_q && !cfg_w3;
    assign sdo_oe  = oe_q && cfg_w3;
endmodule

// File: rtl/sreg_port.sv
// Top level of the serial register access port: synchroniser, engine and register bank.
// Assumes clk is at least four times the serial clock rate; pad buffers sit outside.
module sreg_port
    import sp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic io_reset,
    input  logic sdio_i,
    output logic sdio_o,
    output logic sdio_oe,
    output logic sdo_o,
    output logic sdo_oe
);
    localparam int NSYNC = 4;
    localparam logic [NSYNC-1:0] SYNC_IDLE = 4'b0010; // chip select idles high

    logic [NSYNC-1:0]  s_now, s_prev;
    logic              cs_act, io_rst_s, sclk_rise, sclk_fall, din_s;
    logic              ctrl_lsb, ctrl_w3, wr_en, at_start, cfg_lsb, cfg_w3;
    logic [ADDR_W-1:0] acc_addr;
    logic [DW-1:0]     wr_data, rd_data;

    sp_sync #(.W(NSYNC), .RST_VAL(SYNC_IDLE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdio_i, io_reset, cs_n, sclk}),
        .sync_o  (s_now),
        .prev_o  (s_prev)
    );

    assign cs_act    = !s_now[1];
    assign io_rst_s  = s_now[2];
    assign din_s     = s_now[3];
    assign sclk_rise = cs_act && s_now[0] && !s_prev[0];
    assign sclk_fall = cs_act && !s_now[0] && s_prev[0];

    sp_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .io_rst    (io_rst_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din       (din_s),
        .ctrl_lsb  (ctrl_lsb),
        .ctrl_w3   (ctrl_w3),
        .rd_data   (rd_data),
        .acc_addr  (acc_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sdio_o    (sdio_o),
        .sdio_oe   (sdio_oe),
        .sdo_o     (sdo_o),
        .sdo_oe    (sdo_oe),
        .at_start  (at_start),
        .cfg_lsb   (cfg_lsb),
        .cfg_w3    (cfg_w3)
    );

    sp_regbank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (acc_addr),
        .wr_data  (wr_data),
        .rd_addr  (acc_addr),
        .rd_data  (rd_data),
        .ctrl_lsb (ctrl_lsb),
        .ctrl_w3  (ctrl_w3)
    );
endmodule

// File: rtl/sp_checker.sv
// Protocol properties for the serial register port, attached to the top by bind.
// Assumes the internal names of sreg_port listed in the bind statement.
module sp_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_act,
    input logic io_rst,
    input logic sclk_rise,
    input logic at_start,
    input logic cfg_lsb,
    input logic cfg_w3,
    input logic wr_en,
    input logic sdio_oe,
    input logic sdo_oe
);
    // R8: deselection silences both data outputs
    a_r8_cs_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (!sdio_oe && !sdo_oe));

    // R7: never two drivers at once
    a_r7_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdio_oe && sdo_oe));

    // R9: port reset returns to instruction start
    a_r9_iorst_restart: assert property (@(posedge clk) disable iff (!rst_n)
        io_rst |=> at_start);

    // R11: active configuration frozen once an instruction is under way
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !at_start |=> $stable({cfg_lsb, cfg_w3}));

    // R4: commit follows the final rising edge
    a_r4_commit_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(sclk_rise));

    // R4: a commit lasts a single cycle
    a_r4_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

bind sreg_port sp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .io_rst    (io_rst_s),
    .sclk_rise (sclk_rise),
    .at_start  (at_start),
    .cfg_lsb   (cfg_lsb),
    .cfg_w3    (cfg_w3),
    .wr_en     (wr_en),
    .sdio_oe   (sdio_oe),
    .sdo_oe    (sdo_oe)
);

// File: tb/test_sreg_port.sv
// Self-checking bench: sweeps registers, orders and pin modes, plus abort cases.
module test_sreg_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic io_reset = 1'b0;
    logic sdio_i = 1'b0;
    logic sdio_o, sdio_oe, sdo_o, sdo_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic m_lsb = 1'b0;
    logic m_w3  = 1'b0;
    logic [31:0] model [4];
    logic done = 1'b0;

    always #5 clk = ~clk;

    sreg_port i_sreg_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .io_reset(io_reset),
        .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe)
    );

    function automatic int nbits(input logic [5:0] a);
        if (a == 6'd1) return 8;
        if (a == 6'd2) return 16;
        if (a == 6'd0 || a == 6'd3) return 32;
        return 8;
    endfunction

    function automatic logic [31:0] fit(input logic [5:0] a, input logic [31:0] v);
        int n = nbits(a);
        return (n == 32) ? v : (v & ((32'd1 << n) - 1));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sdio_i = b;
        #80 sclk = 1'b1;
        #80 sclk = 1'b0;
    endtask

    task automatic send_insn(input logic rd, input logic b6, input logic [5:0] a);
        logic [7:0] ib = {rd, b6, a};
        for (int i = 0; i < 8; i++) send_bit(ib[m_lsb ? i : 7 - i]);
    endtask

    task automatic shift_out(input int n, input logic [31:0] v);
        for (int i = 0; i < n; i++) send_bit(v[m_lsb ? i : n - 1 - i]);
    endtask

    task automatic shift_in(input int n, output logic [31:0] v, output logic oe_ok);
        v = '0;
        oe_ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            #75;
            if (m_w3) begin
                if (!(sdo_oe && !sdio_oe)) oe_ok = 1'b0;
                v[m_lsb ? i : n - 1 - i] = sdo_o;
            end else begin
                if (!(sdio_oe && !sdo_oe)) oe_ok = 1'b0;
                v[m_lsb ? i : n - 1 - i] = sdio_o;
            end
            #5 sclk = 1'b1;
            #80 sclk = 1'b0;
        end
    endtask

    task automatic cs_on();
        cs_n = 1'b0;
        #100;
    endtask

    task automatic cs_off();
        #100 cs_n = 1'b1;
        #200;
    endtask

    task automatic note_write(input logic [5:0] a, input logic [31:0] v);
        if (a < 6'd4) model[a[1:0]] = fit(a, v);
        if (a == 6'd0) begin
            m_lsb = v[0];
            m_w3  = v[1];
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] v);
        cs_on();
        send_insn(1'b0, 1'b0, a);
        shift_out(nbits(a), v);
        cs_off();
        note_write(a, v);
    endtask

    task automatic do_read(input logic [5:0] a, output logic [31:0] v, output logic oe_ok);
        cs_on();
        send_insn(1'b1, 1'b0, a);
        shift_in(nbits(a), v, oe_ok);
        cs_off();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(10 * 190000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rv;
        logic ok;
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        #100;

        // R1: reset state
        chk("R1 oe after reset", {31'd0, sdio_oe | sdo_oe}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            do_read(6'(a), rv, ok);
            chk("R1 register zero after reset", rv, 32'd0);
        end

        // R3 R5 R6 R7: sweep modes, registers and patterns
        for (int md = 0; md < 4; md++) begin
            do_write(6'd0, 32'hA5C3_0000 | 32'(md));
            for (int a = 0; a < 4; a++) begin
                for (int k = 0; k < 2; k++) begin
                    logic [31:0] pat = (32'h9E37_79B9 * 32'(k + 3 * a + 7 * md + 1)) ^ 32'(a << 4);
                    if (a == 0) pat = (pat & 32'hFFFF_FFFC) | 32'(md);
                    do_write(6'(a), pat);
                    do_read(6'(a), rv, ok);
                    chk("R3 R5 R6 readback", rv, model[a]);
                    chk("R7 output pin enables", {31'd0, ok}, 32'd1);
                end
            end
            // R10: unmapped read in every mode
            do_read(6'(17 + md), rv, ok);
            chk("R10 unmapped reads zero", rv, 32'd0);
        end
        do_write(6'd0, 32'd0);

        // R10: unmapped write leaves mapped registers untouched
        do_write(6'd37, 32'hFF);
        do_read(6'd37, rv, ok);
        chk("R10 unmapped after write", rv, 32'd0);
        for (int a = 1; a < 4; a++) begin
            do_read(6'(a), rv, ok);
            chk("R10 mapped unchanged", rv, model[a]);
        end

        // R2: bit 6 ignored
        cs_on();
        send_insn(1'b0, 1'b1, 6'd2);
        shift_out(16, 32'h0000_BEEF);
        cs_off();
        note_write(6'd2, 32'h0000_BEEF);
        do_read(6'd2, rv, ok);
        chk("R2 bit six ignored", rv, 32'h0000_BEEF);

        // R8 R4: chip select released mid-write, no partial commit
        cs_on();
        send_insn(1'b0, 1'b0, 6'd3);
        shift_out(16, 32'h1234_5678);
        cs_off();
        chk("R8 oe low while deselected", {31'd0, sdio_oe | sdo_oe}, 32'd0);
        do_read(6'd3, rv, ok);
        chk("R8 R4 abandoned write not committed", rv, model[3]);

        // R8: serial clock toggling while deselected is ignored
        sdio_i = 1'b1;
        for (int i = 0; i < 5; i++) begin
            #80 sclk = 1'b1;
            #80 sclk = 1'b0;
        end
        do_read(6'd1, rv, ok);
        chk("R8 deselected clocks ignored", rv, model[1]);

        // R9: port reset mid-write, then instruction in the same window
        cs_on();
        send_insn(1'b0, 1'b0, 6'd3);
        shift_out(12, 32'hFFFF_FFFF);
        io_reset = 1'b1;
        #60 io_reset = 1'b0;
        #100;
        send_insn(1'b1, 1'b0, 6'd3);
        shift_in(32, rv, ok);
        cs_off();
        chk("R9 registers kept after port reset", rv, model[3]);

        // R12 R11: write control then access in the new order, same window
        cs_on();
        send_insn(1'b0, 1'b0, 6'd1);
        shift_out(8, 32'h5A);
        note_write(6'd1, 32'h5A);
        send_insn(1'b1, 1'b0, 6'd1);
        shift_in(8, rv, ok);
        chk("R12 back-to-back transfers", rv, 32'h5A);
        send_insn(1'b0, 1'b0, 6'd0);
        shift_out(32, 32'h0000_0003);
        note_write(6'd0, 32'h0000_0003);
        send_insn(1'b1, 1'b0, 6'd2);
        shift_in(16, rv, ok);
        cs_off();
        chk("R11 new order from next instruction", rv, model[2]);
        chk("R11 new pin use from next instruction", {31'd0, ok}, 32'd1);

        done = 1'b1;
        finish_run();
    end
endmodule